// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Clock Source

This block turns a 16-bit frequency word into a square wave on the reference clock. A phase accumulator adds an effective increment on every clock while the run input is high. Its top bit is the square output. A one-cycle tick marks each rising edge of that output, and it serves as the timebase for a downstream fixed-ratio PWM stage. The output frequency is W × 2^-16 × f_ref, where W is the effective increment.

Software loads the frequency word as two bytes over one byte bus. A high-byte write only stages the byte. A low-byte write commits the staged high byte and the incoming low byte together, so the accumulator never sees a half-written word. Words below 0x8000 are used as they are. Words at or above 0x8000 are replaced by their 16-bit two's complement. A power-of-two word therefore yields an exact 50% duty cycle. The intended range for clocking the PWM stage runs from 1 to 32768.

Top module: `nco_vfgen`

## Requirements
- R1: While reset is asserted and after it is released, sq_o and tick_o are 0 and the committed word is 0x0000, so the accumulator does not advance.
- R2: A cycle with hi_wr_i high stores wr_byte_i into a staging byte only. The output pattern does not change until a later low-byte write.
- R3: A cycle with lo_wr_i high commits {staged high byte, wr_byte_i} as the new word. In the same cycle, the accumulator still adds the increment derived from the previous word. The new increment applies from the next clock on.
- R4: For a word below 0x8000, the effective increment W equals the word.
- R5: For a word of 0x8000 or more, W is (0x10000 − word) mod 0x10000. So 0x8000 gives 0x8000, 0xF000 gives 0x1000 and 0xFFFF gives 1.
- R6: While start_i is high, the 16-bit accumulator adds W modulo 2^16 on every clock. Starting from zero, it holds k·W mod 2^16 after k clocks.
- R7: When start_i is low at a clock edge, the accumulator is 0 after that edge, so sq_o is 0 in the following cycle.
- R8: sq_o is accumulator bit 15. With a power-of-two W, exactly half of any whole number of output periods is high.
- R9: tick_o is high for exactly one cycle, the cycle in which sq_o has just gone from 0 to 1. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run enable; low clears the accumulator |
| hi_wr_i | input | 1 | Stage wr_byte_i as the word's high byte |
| lo_wr_i | input | 1 | Commit staged high byte plus wr_byte_i as the word |
| wr_byte_i | input | BYTE_W | Byte write data |
| sq_o | output | 1 | Square-wave output (accumulator MSB) |
| tick_o | output | 1 | One-cycle pulse on each sq_o rising edge |

## Verification
The bound checker checks several things on every cycle. A tick appears exactly on a rising edge of the square output and never twice in a row. The accumulator advances by the increment that was current in the previous cycle. A stopped generator drops its output. The committed word changes only on a low-byte write. Only the bench's scenarios can show the rest: the folding of large words into their two's complement, the tick count and high-cycle count over whole periods for power-of-two words, and the fact that a high-byte write alone leaves the pattern unchanged. The bench's behavioural reference model is compared against both outputs on every clock.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int unsigned NCO_BYTE_W_DEF = 8;

   typedef enum logic [0:0] {
      FOLD_RAW = 1'b0,
      FOLD_NEG = 1'b1
   } fold_mode_e;
endpackage

// File: rtl/nco_word_reg.sv
module nco_word_reg #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hi_wr_i,
   input  logic              lo_wr_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   output logic [WORD_W-1:0] word_o
);
   logic [BYTE_W-1:0] stage_q;
   logic [WORD_W-1:0] word_q;

   // staging byte: never seen by the accumulator on its own
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q <= '0;
      else if (hi_wr_i) stage_q <= wr_byte_i;
   end

   // whole word committed on the low-byte write only
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (lo_wr_i) word_q <= {stage_q, wr_byte_i};
   end

   assign word_o = word_q;
endmodule

// File: rtl/nco_fold.sv
module nco_fold
   import nco_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter fold_mode_e  MODE   = FOLD_NEG
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] inc_o
);
   generate
      if (MODE == FOLD_NEG) begin : g_fold
         logic [WORD_W-1:0] neg;
         assign neg   = (~word_i) + {{(WORD_W-1){1'b0}}, 1'b1};
         assign inc_o = word_i[WORD_W-1] ? neg : word_i;
      end else begin : g_raw
         assign inc_o = word_i;
      end
   endgenerate
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (!run_i) acc_q <= '0;
      else             acc_q <= acc_q + inc_i;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/nco_edge.sv
module nco_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/nco_vfgen.sv
module nco_vfgen
   import nco_pkg::*;
#(
   parameter int unsigned BYTE_W = NCO_BYTE_W_DEF,
   parameter fold_mode_e  FOLD   = FOLD_NEG,
   localparam int unsigned WORD_W = 2 * BYTE_W,
   localparam int unsigned MSB    = WORD_W - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              hi_wr_i,
   input  logic              lo_wr_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   output logic              sq_o,
   output logic              tick_o
);
   generate
      if (BYTE_W < 2 || BYTE_W > 32) begin : g_bad_width
         $error("nco_vfgen: BYTE_W must lie in 2..32");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] eff_w;
   logic [WORD_W-1:0] acc_q;

   nco_word_reg #(.BYTE_W(BYTE_W)) u_word (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hi_wr_i   (hi_wr_i),
      .lo_wr_i   (lo_wr_i),
      .wr_byte_i (wr_byte_i),
      .word_o    (word_q)
   );

   nco_fold #(.WORD_W(WORD_W), .MODE(FOLD)) u_fold (
      .word_i (word_q),
      .inc_o  (eff_w)
   );

   nco_accum #(.ACC_W(WORD_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (start_i),
      .inc_i  (eff_w),
      .acc_o  (acc_q)
   );

   assign sq_o = acc_q[MSB];

   nco_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (sq_o),
      .rise_o (tick_o)
   );
endmodule

// File: rtl/nco_vfgen_chk.sv
module nco_vfgen_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              lo_wr_i,
   input logic              sq_o,
   input logic              tick_o,
   input logic [WORD_W-1:0] word_q,
   input logic [WORD_W-1:0] eff_w,
   input logic [WORD_W-1:0] acc_q
);
   // R9: tick lasts one cycle
   a_r9_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
   // R9: tick only while the square output is high
   a_r9_tick_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> sq_o);
   // R9: every rising edge of the square output carries a tick
   a_r9_rise_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sq_o) |-> tick_o);
   // R7: stopping clears the output
   a_r7_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (!sq_o && acc_q == '0));
   // R6: running accumulator advances by the previous increment
   a_r6_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> acc_q == WORD_W'($past(acc_q) + $past(eff_w)));
   // R2: committed word moves only on a low-byte write
   a_r2_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lo_wr_i |=> $stable(word_q));
endmodule

bind nco_vfgen nco_vfgen_chk #(.WORD_W(WORD_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .lo_wr_i (lo_wr_i),
   .sq_o    (sq_o),
   .tick_o  (tick_o),
   .word_q  (word_q),
   .eff_w   (eff_w),
   .acc_q   (acc_q)
);

// File: tb/test_nco_vfgen.sv
`timescale 1ns/1ps
module test_nco_vfgen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       hi_wr = 1'b0;
   logic       lo_wr = 1'b0;
   logic [7:0] wbyte = 8'h00;
   logic       sq, tick;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string req_tag = "R1";
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   // behavioural reference state
   int m_word = 0, m_stage = 0, m_acc = 0, m_prev = 0;

   always #2 clk = ~clk;

   nco_vfgen i_nco_vfgen (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hi_wr_i(hi_wr),
      .lo_wr_i(lo_wr), .wr_byte_i(wbyte), .sq_o(sq), .tick_o(tick)
   );

   function automatic int eff_of(int w);
      return (w < 32768) ? w : ((65536 - w) % 65536);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_word = 0; m_stage = 0; m_acc = 0; m_prev = 0;
      end else begin
         m_prev = (m_acc >> 15) & 1;
         m_acc  = start ? ((m_acc + eff_of(m_word)) % 65536) : 0;
         if (lo_wr) m_word = (m_stage << 8) | int'(wbyte);
         if (hi_wr) m_stage = int'(wbyte);
      end
   end

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         check(req_tag, int'(sq), (m_acc >> 15) & 1, "sq_o vs model");
         check("R9", int'(tick), ((m_acc >> 15) & 1) & (1 - m_prev), "tick_o vs model");
      end
   end

   task automatic wr_word(int w);
      @(negedge clk); hi_wr = 1'b1; wbyte = 8'((w >> 8) & 255);
      @(negedge clk); hi_wr = 1'b0; lo_wr = 1'b1; wbyte = 8'(w & 255);
      @(negedge clk); lo_wr = 1'b0;
   endtask

   // counts ticks and high cycles over n cycles (sampled at negedge)
   task automatic window(int n, output int nt, output int nh);
      nt = 0; nh = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #0.1;
         nt += int'(tick); nh += int'(sq);
      end
   endtask

   task automatic pow2_run(string tag, int w, int exp_t, int exp_h);
      int nt, nh;
      start = 1'b0;
      wr_word(w);
      start = 1'b1;
      window(64, nt, nh);
      check(tag, nt, exp_t, $sformatf("tick count word %h", w));
      check("R8", nh, exp_h, $sformatf("high cycles word %h", w));
   endtask

   initial begin
      int nt, nh;
      repeat (3) @(negedge clk);
      check("R1", int'(sq), 0, "sq_o in reset");
      check("R1", int'(tick), 0, "tick_o in reset");
      rst_n = 1'b1;
      cmp_en = 1'b1;
      start = 1'b1;
      window(16, nt, nh);
      check("R1", nh, 0, "zero word keeps sq_o low");

      req_tag = "R4";
      pow2_run("R4", 16'h4000, 16, 32);
      req_tag = "R5";
      pow2_run("R5", 16'h8000, 32, 32);
      pow2_run("R5", 16'hF000, 4, 32);

      // R2: high byte alone leaves the pattern unchanged
      req_tag = "R2";
      pow2_run("R2", 16'h4000, 16, 32);
      @(negedge clk); hi_wr = 1'b1; wbyte = 8'h12;
      @(negedge clk); hi_wr = 1'b0;
      window(64, nt, nh);
      check("R2", nt, 16, "ticks after high-byte-only write");

      // R3/R6: non power-of-two words, switched while running
      req_tag = "R3";
      wr_word(16'h0300);
      repeat (100) @(negedge clk);
      req_tag = "R6";
      wr_word(16'hC123);
      repeat (200) @(negedge clk);
      wr_word(16'h7FFF);
      repeat (50) @(negedge clk);

      // R7: stop
      req_tag = "R7";
      start = 1'b0;
      @(negedge clk);
      check("R7", int'(sq), 0, "sq_o after stop");
      repeat (5) @(negedge clk);
      start = 1'b1;
      req_tag = "R6";
      repeat (40) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      while (!done && cycles < 20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule